// File: doc/BRIEF.md
# Prescaled Watchdog Timer

This block is a watchdog for a small processor core. A divide-by-twelve tick generator turns the oscillator clock into machine-cycle ticks. A prescaler divides those ticks by a power of two from 2 to 256. The prescaled ticks drive a 15-bit counter. If the counter wraps before software clears it, the block raises a one-clock chip-reset request. Software controls the watchdog through a small control register. That register is also loaded at power-on from fuse-style option inputs, so the watchdog can be running before any code executes.

A dedicated register bit decides whether counting goes on while the core reports idle. When that bit is 0, an idle core freezes the tick generator, the prescaler and the counter. When it is 1, they keep running. Once the enable bit is set, only a power-on reset can clear it.

A small sequencer tracks the operating mode and produces the reset-request pulse. It has four states:
- `ST_OFF`: disabled.
- `ST_COUNT`: counting.
- `ST_HOLD`: frozen by idle.
- `ST_FIRE`: request pulse.

Its transitions are:
- OFF→COUNT when enabled and not frozen.
- OFF→HOLD when enabled while frozen.
- COUNT→HOLD when idle freezes the count.
- HOLD→COUNT when the freeze ends.
- COUNT→FIRE on counter wrap.
- FIRE→COUNT or FIRE→HOLD on the following cycle.

Top module: `wdt_core`

## Requirements
- R1: With `hw_en_i` high during power-on reset, the readback is {2'b00, 1, 0, hw_idle_i, hw_ps_i}. Enable sits at bit 5, idle-count at bit 3 and prescale at bits 2:0, so idle option 1 with prescale option 5 reads 0x2D.
- R2: With `hw_en_i` low during power-on reset, the readback is 0x00. The watchdog stays disabled until software writes 1 to bit 5.
- R3: A write updates idle-count from data bit 3 and prescale from data bits 2:0. Readback bits 7:6 and bit 4 always read 0.
- R4: Once enable (bit 5) is 1, writing 0 to it has no effect. Only power-on reset clears it.
- R5: The counter period is MC_DIV × 2^(code+1) × 2^CNT_W clocks, where code is the prescale field. With the defaults this is 12 × prescaler × 32768 clocks. The request appears in the cycle after the last counted edge.
- R6: Writing 1 to data bit 4 zeroes the tick generator, prescaler and counter on that edge. A full period is then counted from the edge that follows.
- R7: While `idle_i` is high and idle-count is 0, nothing advances. With idle-count at 1, counting continues while idle.
- R8: `rst_req_o` is high for exactly one clock. Counting restarts from zero, so the next request follows one full period after the first.
- R9: While enable is 0, `rst_req_o` never rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous |
| idle_i | input | 1 | Core idle indicator |
| hw_en_i | input | 1 | Fuse option: enable watchdog at power-on |
| hw_idle_i | input | 1 | Fuse option: idle-count value loaded at power-on |
| hw_ps_i | input | 3 | Fuse option: prescale code loaded at power-on |
| wr_en_i | input | 1 | Control-register write strobe |
| wr_data_i | input | 6 | Write data: [5] enable, [4] clear, [3] idle-count, [2:0] prescale |
| ctrl_rd_o | output | 8 | Control-register readback |
| rst_req_o | output | 1 | One-clock chip-reset request |

## Verification
A wrong count in the tick generator, prescaler or counter stays hidden until the next wrap. It then shows as a request that arrives early or late, so the bench measures the exact cycle distance from reset, write or clear to the pulse for every prescale code. A freeze that leaks while idle shows as a request that comes too soon once idle ends. A clear that misses a stage shows as a shortened period after the clear write. Register faults show at once on the readback port.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
    localparam int PS_W     = 3;
    localparam int CTRL_W   = 6;
    localparam int RD_W     = 8;
    localparam int EN_BIT   = 5;
    localparam int CLR_BIT  = 4;
    localparam int IDLE_BIT = 3;

    typedef enum logic [1:0] {
        ST_OFF,
        ST_COUNT,
        ST_HOLD,
        ST_FIRE
    } wdt_state_e;

    typedef struct packed {
        logic            en;
        logic            idle_cnt;
        logic [PS_W-1:0] ps;
    } wdt_cfg_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
`timescale 1ns/1ps
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              por_n,
    input  logic              hw_en_i,
    input  logic              hw_idle_i,
    input  logic [PS_W-1:0]   hw_ps_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output wdt_cfg_t          cfg_o,
    output logic              clr_o,
    output logic [RD_W-1:0]   rd_o
);
    wdt_cfg_t cfg_q;

    // Fuse options are static, so loading them on the asynchronous reset is safe.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            if (hw_en_i) begin
                cfg_q <= '{en: 1'b1, idle_cnt: hw_idle_i, ps: hw_ps_i};
            end else begin
                cfg_q <= '0;
            end
        end else if (wr_en_i) begin
            cfg_q.en       <= cfg_q.en | wr_data_i[EN_BIT];
            cfg_q.idle_cnt <= wr_data_i[IDLE_BIT];
            cfg_q.ps       <= wr_data_i[PS_W-1:0];
        end
    end

    always_comb begin
        cfg_o = cfg_q;
        clr_o = wr_en_i & wr_data_i[CLR_BIT];
        rd_o  = {{(RD_W-CTRL_W){1'b0}}, cfg_q.en, 1'b0, cfg_q.idle_cnt, cfg_q.ps};
    end

    // R4
    en_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
        cfg_q.en |=> cfg_q.en);

    // R3
    cfg_write_chk: assert property (@(posedge clk) disable iff (!por_n)
        wr_en_i |=> (cfg_q.ps == $past(wr_data_i[PS_W-1:0])) &&
                    (cfg_q.idle_cnt == $past(wr_data_i[IDLE_BIT])));
endmodule

// File: rtl/wdt_tick_gen.sv
`timescale 1ns/1ps
module wdt_tick_gen #(
    parameter int MC_DIV = 12
) (
    input  logic clk,
    input  logic por_n,
    input  logic run_i,
    input  logic clr_i,
    output logic mc_tick_o
);
    localparam int           MC_W    = $clog2(MC_DIV);
    localparam logic [MC_W-1:0] MC_LAST = MC_W'(MC_DIV - 1);

    logic [MC_W-1:0] mc_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            mc_q <= '0;
        end else if (clr_i) begin
            mc_q <= '0;
        end else if (run_i) begin
            mc_q <= (mc_q == MC_LAST) ? '0 : mc_q + 1'b1;
        end
    end

    always_comb mc_tick_o = run_i && (mc_q == MC_LAST);

    // R7
    tick_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (!run_i && !clr_i) |=> $stable(mc_q));
endmodule

// File: rtl/wdt_prescaler.sv
`timescale 1ns/1ps
module wdt_prescaler
    import wdt_pkg::*;
(
    input  logic            clk,
    input  logic            por_n,
    input  logic            mc_tick_i,
    input  logic            restart_i,
    input  logic [PS_W-1:0] ps_i,
    output logic            pre_tick_o
);
    localparam int PRE_W  = 2 ** PS_W;
    localparam int N_TAPS = 2 ** PS_W;

    logic [PRE_W-1:0]  pre_q;
    logic [N_TAPS-1:0] tap;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            pre_q <= '0;
        end else if (restart_i) begin
            pre_q <= '0;
        end else if (mc_tick_i) begin
            pre_q <= pre_q + 1'b1;
        end
    end

    // Code g divides by 2^(g+1): the tap fires when the low g+1 bits are all ones.
    for (genvar g = 0; g < N_TAPS; g++) begin : g_tap
        assign tap[g] = &pre_q[g:0];
    end

    always_comb pre_tick_o = mc_tick_i & tap[ps_i];

    // R6
    pre_restart_chk: assert property (@(posedge clk) disable iff (!por_n)
        restart_i |=> (pre_q == '0));
endmodule

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
    parameter int CNT_W = 15
) (
    input  logic clk,
    input  logic por_n,
    input  logic pre_tick_i,
    input  logic clr_i,
    output logic ovf_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= '0;
        end else if (pre_tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb ovf_o = pre_tick_i & (&cnt_q);

    // R8
    wrap_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        ovf_o |=> (cnt_q == '0));

    // R6
    clr_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
        clr_i |=> (cnt_q == '0));
endmodule

// File: rtl/wdt_core.sv
`timescale 1ns/1ps
module wdt_core
    import wdt_pkg::*;
#(
    parameter int MC_DIV = 12,
    parameter int CNT_W  = 15
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              idle_i,
    input  logic              hw_en_i,
    input  logic              hw_idle_i,
    input  logic [PS_W-1:0]   hw_ps_i,
    input  logic              wr_en_i,
    input  logic [CTRL_W-1:0] wr_data_i,
    output logic [RD_W-1:0]   ctrl_rd_o,
    output logic              rst_req_o
);
    wdt_cfg_t   cfg;
    logic       clr;
    logic       frozen;
    logic       run;
    logic       mc_tick;
    logic       pre_tick;
    logic       ovf;
    wdt_state_e state_q;
    wdt_state_e state_d;

    wdt_ctrl_reg u_ctrl (
        .clk       (clk),
        .por_n     (por_n),
        .hw_en_i   (hw_en_i),
        .hw_idle_i (hw_idle_i),
        .hw_ps_i   (hw_ps_i),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .cfg_o     (cfg),
        .clr_o     (clr),
        .rd_o      (ctrl_rd_o)
    );

    always_comb begin
        frozen = cfg.en & idle_i & ~cfg.idle_cnt;
        run    = cfg.en & ~frozen;
    end

    wdt_tick_gen #(.MC_DIV(MC_DIV)) u_tick (
        .clk       (clk),
        .por_n     (por_n),
        .run_i     (run),
        .clr_i     (clr),
        .mc_tick_o (mc_tick)
    );

    wdt_prescaler u_pre (
        .clk        (clk),
        .por_n      (por_n),
        .mc_tick_i  (mc_tick),
        .restart_i  (clr | ovf),
        .ps_i       (cfg.ps),
        .pre_tick_o (pre_tick)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .por_n      (por_n),
        .pre_tick_i (pre_tick),
        .clr_i      (clr),
        .ovf_o      (ovf)
    );

    // Mode sequencer: state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    // Mode sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (cfg.en) state_d = frozen ? ST_HOLD : ST_COUNT;
            end
            ST_COUNT: begin
                if (ovf)         state_d = ST_FIRE;
                else if (frozen) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (ovf)          state_d = ST_FIRE;
                else if (!frozen) state_d = ST_COUNT;
            end
            ST_FIRE: begin
                if (ovf) state_d = ST_FIRE;
                else     state_d = frozen ? ST_HOLD : ST_COUNT;
            end
        endcase
    end

    // Mode sequencer: outputs
    always_comb begin
        rst_req_o = (state_q == ST_FIRE);
    end

    // R8
    req_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
        rst_req_o |=> !rst_req_o);

    // R9
    off_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
        !cfg.en |=> !rst_req_o);

    // R7
    idle_freeze_chk: assert property (@(posedge clk) disable iff (!por_n)
        (frozen && !clr) |-> !mc_tick);
endmodule

// File: tb/wdt_core_test.sv
`timescale 1ns/1ps
module wdt_core_test;
    localparam int MC_DIV = 3;
    localparam int CNT_W  = 4;
    localparam int BASE   = MC_DIV * 2 * (2 ** CNT_W);

    typedef struct packed {
        logic [2:0] ps;
        logic       hw_idle;
        logic       idle_in;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{3'd0, 1'b0, 1'b0},
        '{3'd1, 1'b1, 1'b1},
        '{3'd2, 1'b1, 1'b0},
        '{3'd3, 1'b0, 1'b0},
        '{3'd4, 1'b1, 1'b1},
        '{3'd5, 1'b1, 1'b0},
        '{3'd6, 1'b0, 1'b0},
        '{3'd7, 1'b1, 1'b1}
    };

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       idle = 1'b0;
    logic       hw_en = 1'b0;
    logic       hw_idle = 1'b0;
    logic [2:0] hw_ps = 3'd0;
    logic       wr_en = 1'b0;
    logic [5:0] wr_data = 6'd0;
    logic [7:0] rd;
    logic       rst_req;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    wdt_core #(.MC_DIV(MC_DIV), .CNT_W(CNT_W)) uut (
        .clk       (clk),
        .por_n     (por_n),
        .idle_i    (idle),
        .hw_en_i   (hw_en),
        .hw_idle_i (hw_idle),
        .hw_ps_i   (hw_ps),
        .wr_en_i   (wr_en),
        .wr_data_i (wr_data),
        .ctrl_rd_o (rd),
        .rst_req_o (rst_req)
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic por(input logic en, input logic hi, input logic [2:0] ps, input logic idl);
        @(negedge clk);
        por_n   = 1'b0;
        hw_en   = en;
        hw_idle = hi;
        hw_ps   = ps;
        idle    = idl;
        repeat (2) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic wr(input logic [5:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_req(input int limit, output int n);
        n = 0;
        do begin
            @(posedge clk);
            n++;
            @(negedge clk);
        end while (!rst_req && n < limit);
    endtask

    initial begin
        int n;
        // Table-driven: power-on load and period for each prescale code
        for (int i = 0; i < 8; i++) begin
            int exp_n;
            exp_n = BASE << VECS[i].ps;
            por(1'b1, VECS[i].hw_idle, VECS[i].ps, VECS[i].idle_in);
            chk("R1 power-on readback", int'(rd), int'({2'b00, 1'b1, 1'b0, VECS[i].hw_idle, VECS[i].ps}));
            wait_req(exp_n + 20, n);
            chk("R5 R7 period", n, exp_n);
        end
        idle = 1'b0;

        // R1 explicit example value 0x2D
        por(1'b1, 1'b1, 3'd5, 1'b0);
        chk("R1 example 0x2D", int'(rd), 8'h2D);

        // R8 single-clock pulse then full restart
        por(1'b1, 1'b0, 3'd0, 1'b0);
        wait_req(BASE + 20, n);
        chk("R8 first request", n, BASE);
        chk("R8 pulse high", int'(rst_req), 1);
        @(posedge clk);
        @(negedge clk);
        chk("R8 pulse one clock", int'(rst_req), 0);
        wait_req(BASE + 20, n);
        chk("R8 second period", n, BASE - 1);

        // R7 freeze while idle with idle-count 0
        por(1'b1, 1'b0, 3'd0, 1'b0);
        repeat (40) @(posedge clk);
        @(negedge clk);
        idle = 1'b1;
        wait_req(200, n);
        chk("R7 no request while frozen", n, 200);
        idle = 1'b0;
        wait_req(BASE + 20, n);
        chk("R7 remainder after idle", n, BASE - 40);

        // R6 clear restarts full period; R4 enable write of 0 ignored
        por(1'b1, 1'b0, 3'd0, 1'b0);
        repeat (90) @(posedge clk);
        chk("R6 no early request", int'(rst_req), 0);
        wr(6'h10);
        chk("R4 R3 readback after clear", int'(rd), 8'h20);
        wait_req(BASE + 20, n);
        chk("R6 full period after clear", n, BASE);

        // R2 R9 disabled at power-on, software enable
        por(1'b0, 1'b1, 3'd6, 1'b0);
        chk("R2 disabled readback", int'(rd), 0);
        wait_req(2000, n);
        chk("R9 no request when disabled", n, 2000);
        wr(6'h2A);
        chk("R2 software enable readback", int'(rd), 8'h2A);
        wr(6'h0A);
        chk("R4 enable sticky", int'(rd), 8'h2A);
        wr(6'h1A);
        wait_req((BASE << 2) + 20, n);
        chk("R5 R2 period after software enable", n, BASE << 2);

        // R3 reserved and clear bits read zero
        wr(6'h3F);
        chk("R3 readback masks", int'(rd), 8'h2F);
        wr(6'h14);
        chk("R3 field update", int'(rd), 8'h24);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nchk, nfail);
            $finish;
        end
    end
endmodule